// File: doc/BRIEF.md
# Page-Aligned Serial NOR Program Sequencer

This block turns one program request (start address and byte count) into the command sequence that a serial NOR flash needs to take that data. It sits above a command port that does the serial shifting. The request is cut into chunks so that no chunk runs past the end of a flash page. The page size is given at run time as a power of two. Every chunk is wrapped in the same handshake:
- a write-enable command;
- a status read that must show the write-enable latch set;
- the page-program command with its address and length, followed by that many data bytes;
- status reads, spaced by a fixed number of idle cycles, until the busy flag clears.

Data bytes arrive on a ready/valid byte stream and are forwarded one for one to the command port while a page-program command is open. The block pulses `done` when the request ends and holds an error code beside it. The code reports one of: success, a request made before the device was initialised, a write-enable latch that failed to set, or a device that stayed busy through the whole retry budget.

Top module: `nor_prog_seq`

## Requirements
- R1: Each page-program command (opcode 0x02) carries the chunk address and a chunk length equal to the smaller of the bytes left and (2^page_lg minus address mod 2^page_lg). After the chunk the address advances by the chunk length, and the request ends once no bytes are left. page_lg = 8 gives 256-byte pages.
- R2: Every chunk starts with a write-enable command (opcode 0x06), followed by a status read (opcode 0x05), before its page-program command. A command is held on the port until it is accepted.
- R3: If the status returned after write-enable has the latch flag (rsp_flags bit 1) clear, no page-program is issued. The request then ends with error code 2.
- R4: After a page-program response the block issues status reads while the busy flag (rsp_flags bit 0) is 1. The first read and each later read appear exactly POLL_GAP+1 cycles after the response before them is taken.
- R5: If MAX_POLLS status reads in a row all show busy, the request ends with error code 3. A read numbered MAX_POLLS that shows idle lets the sequence continue.
- R6: A request taken while init_done is low ends on the next cycle with error code 1 and issues no command.
- R7: A request with zero length ends on the next cycle with error code 0 and issues no command.
- R8: During a page-program exactly the chunk length in bytes is passed from the input stream to tx, in stream order. in_ready is high only in that data phase and only while tx_ready is high.
- R9: `done` is a one-cycle pulse, after which req_ready is high again. A request that completes normally reports error code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Device initialisation complete |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| page_lg | input | PGLG_W | log2 of page size, held during a request |
| done | output | 1 | Request finished (one cycle) |
| err | output | 2 | 0 ok, 1 not initialised, 2 latch not set, 3 busy timeout |
| in_valid | input | 1 | Data byte present |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Data byte taken |
| cmd_valid | output | 1 | Command request to the serial layer |
| cmd_ready | input | 1 | Command accepted |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | ADDR_W | Page-program address |
| cmd_len | output | LEN_W | Page-program byte count, 0 for other commands |
| tx_valid | output | 1 | Program byte to the serial layer |
| tx_data | output | 8 | Program byte |
| tx_ready | input | 1 | Serial layer takes the byte |
| rsp_valid | input | 1 | Current command finished |
| rsp_flags | input | 2 | Low status bits of a status read: bit 1 latch, bit 0 busy |

## Verification
The main check is a sweep over small pages of 4 and 8 bytes. Every start address from 0 to 9 is paired with every length from 0 to 12. This separates a chunk that ends exactly on a page edge from one that stops short of it or spans several pages. Along the sweep, the number of busy polls per chunk and the stall pattern on the data and tx handshakes change from request to request. This shows that poll counting and byte forwarding do not depend on the chunk's position. Single cases cover the 256-byte page with a crossing, a whole-page write, a latch failure, and a busy count one below, equal to and far above the retry limit, which separates a late success from a timeout. They also cover a request before initialisation and a zero-length request.

// File: rtl/nps_pkg.sv
`timescale 1ns/1ps
package nps_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_RDSR = 8'h05;

    localparam int SR_WIP = 0;
    localparam int SR_WEL = 1;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_DEV  = 2'd1,
        ERR_WEL  = 2'd2,
        ERR_NRDY = 2'd3
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WE_CMD,
        S_WE_RSP,
        S_LC_CMD,
        S_LC_RSP,
        S_PG_CMD,
        S_PG_DATA,
        S_PG_RSP,
        S_GAP,
        S_PL_CMD,
        S_PL_RSP,
        S_FIN
    } seq_st_e;

    function automatic logic is_cmd_state(seq_st_e s);
        return (s == S_WE_CMD) || (s == S_LC_CMD) || (s == S_PG_CMD) || (s == S_PL_CMD);
    endfunction

    function automatic logic [7:0] st_opcode(seq_st_e s);
        logic [7:0] op;
        case (s)
            S_WE_CMD: op = OP_WREN;
            S_PG_CMD: op = OP_PROG;
            default:  op = OP_RDSR;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/nps_chunk_calc.sv
`timescale 1ns/1ps
module nps_chunk_calc #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int PGLG_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  left,
    input  logic [PGLG_W-1:0] pg_lg,
    output logic [LEN_W-1:0]  chunk
);
    // One spare bit so a full page (2^pg_lg) is representable.
    localparam int CW = LEN_W + 1;

    logic [CW-1:0] pg_sz;
    logic [CW-1:0] addr_lo;
    logic [CW-1:0] offset;
    logic [CW-1:0] room;

    always_comb begin
        pg_sz   = CW'(1) << pg_lg;
        addr_lo = CW'(addr);
        offset  = addr_lo & (pg_sz - CW'(1));
        room    = pg_sz - offset;
        if ({1'b0, left} < room) begin
            chunk = left;
        end else begin
            chunk = room[LEN_W-1:0];
        end
    end
endmodule

// File: rtl/nps_poll_timer.sv
`timescale 1ns/1ps
module nps_poll_timer #(
    parameter int GAP_CYC   = 16,
    parameter int MAX_READS = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic gap_load,
    input  logic poll_clr,
    input  logic poll_read,
    output logic gap_done,
    output logic last_read
);
    localparam int GW = $clog2(GAP_CYC + 2);
    localparam int PW = $clog2(MAX_READS + 1);

    logic [PW-1:0] reads;

    generate
        if (GAP_CYC == 0) begin : g_nogap
            // No spacing wanted: the gap is always already over.
            assign gap_done = 1'b1;
        end else begin : g_gap
            logic [GW-1:0] gap_cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    gap_cnt <= '0;
                end else if (gap_load) begin
                    gap_cnt <= GW'(GAP_CYC);
                end else if (gap_cnt != '0) begin
                    gap_cnt <= gap_cnt - 1'b1;
                end
            end
            assign gap_done = (gap_cnt == '0) && !gap_load;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || poll_clr) begin
            reads <= '0;
        end else if (poll_read) begin
            reads <= reads + 1'b1;
        end
    end

    // High while the read now in flight is the final one allowed.
    assign last_read = (reads == PW'(MAX_READS - 1));
endmodule

// File: rtl/nps_byte_gate.sv
`timescale 1ns/1ps
module nps_byte_gate #(
    parameter int LEN_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              active,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              last_beat
);
    logic [LEN_W-1:0] left;
    logic             beat;

    assign tx_valid  = active && in_valid;
    assign in_ready  = active && tx_ready;
    assign tx_data   = in_data;
    assign beat      = tx_valid && tx_ready;
    assign last_beat = beat && (left == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (load) begin
            left <= load_len;
        end else if (beat) begin
            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/nor_prog_seq.sv
`timescale 1ns/1ps
module nor_prog_seq
    import nps_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = 16,
    parameter int PGLG_W    = 4,
    parameter int MAX_POLLS = 10000,
    parameter int POLL_GAP  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_done,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [PGLG_W-1:0] page_lg,
    output logic              done,
    output logic [1:0]        err,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [7:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_flags
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
    } cursor_t;

    seq_st_e           st;
    cursor_t           cur;
    logic [PGLG_W-1:0] pg_lg_q;
    logic [LEN_W-1:0]  chunk_q;
    logic [LEN_W-1:0]  chunk_nx;
    err_e              err_q;

    logic gap_done, last_read, last_beat;
    logic gate_load, gap_load, poll_clr, poll_read;
    logic sr_busy, sr_latch;

    assign sr_busy  = rsp_flags[SR_WIP];
    assign sr_latch = rsp_flags[SR_WEL];

    nps_chunk_calc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PGLG_W(PGLG_W)
    ) u_chunk (
        .addr  (cur.addr),
        .left  (cur.left),
        .pg_lg (pg_lg_q),
        .chunk (chunk_nx)
    );

    nps_poll_timer #(
        .GAP_CYC(POLL_GAP), .MAX_READS(MAX_POLLS)
    ) u_poll (
        .clk       (clk),
        .rst       (rst),
        .gap_load  (gap_load),
        .poll_clr  (poll_clr),
        .poll_read (poll_read),
        .gap_done  (gap_done),
        .last_read (last_read)
    );

    nps_byte_gate #(
        .LEN_W(LEN_W), .DATA_W(8)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .load      (gate_load),
        .load_len  (chunk_q),
        .active    (st == S_PG_DATA),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .last_beat (last_beat)
    );

    // Control strobes to the helpers
    always_comb begin
        gate_load = (st == S_PG_CMD) && cmd_ready;
        gap_load  = 1'b0;
        poll_clr  = 1'b0;
        poll_read = 1'b0;
        if ((st == S_PG_RSP) && rsp_valid) begin
            gap_load = 1'b1;
            poll_clr = 1'b1;
        end
        if ((st == S_PL_RSP) && rsp_valid) begin
            poll_read = 1'b1;
            if (sr_busy && !last_read) begin
                gap_load = 1'b1;
            end
        end
    end

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cur     <= '0;
            pg_lg_q <= '0;
            chunk_q <= '0;
            err_q   <= ERR_NONE;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        if (!init_done) begin
                            err_q <= ERR_DEV;
                            st    <= S_FIN;
                        end else if (req_len == '0) begin
                            err_q <= ERR_NONE;
                            st    <= S_FIN;
                        end else begin
                            err_q    <= ERR_NONE;
                            cur.addr <= req_addr;
                            cur.left <= req_len;
                            pg_lg_q  <= page_lg;
                            st       <= S_WE_CMD;
                        end
                    end
                end
                S_WE_CMD: if (cmd_ready) st <= S_WE_RSP;
                S_WE_RSP: if (rsp_valid) st <= S_LC_CMD;
                S_LC_CMD: if (cmd_ready) st <= S_LC_RSP;
                S_LC_RSP: begin
                    if (rsp_valid) begin
                        if (sr_latch) begin
                            chunk_q <= chunk_nx;
                            st      <= S_PG_CMD;
                        end else begin
                            err_q <= ERR_WEL;
                            st    <= S_FIN;
                        end
                    end
                end
                S_PG_CMD:  if (cmd_ready) st <= S_PG_DATA;
                S_PG_DATA: if (last_beat) st <= S_PG_RSP;
                S_PG_RSP: begin
                    if (rsp_valid) begin
                        cur.addr <= cur.addr + ADDR_W'(chunk_q);
                        cur.left <= cur.left - chunk_q;
                        st       <= S_GAP;
                    end
                end
                S_GAP:    if (gap_done) st <= S_PL_CMD;
                S_PL_CMD: if (cmd_ready) st <= S_PL_RSP;
                S_PL_RSP: begin
                    if (rsp_valid) begin
                        if (!sr_busy) begin
                            st <= (cur.left == '0) ? S_FIN : S_WE_CMD;
                        end else if (last_read) begin
                            err_q <= ERR_NRDY;
                            st    <= S_FIN;
                        end else begin
                            st <= S_GAP;
                        end
                    end
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (st == S_IDLE);
    assign done      = (st == S_FIN);
    assign err       = err_q;
    assign cmd_valid = is_cmd_state(st);
    assign cmd_op    = st_opcode(st);
    assign cmd_addr  = cur.addr;
    assign cmd_len   = (st == S_PG_CMD) ? chunk_q : '0;
endmodule

// File: rtl/nps_checker.sv
`timescale 1ns/1ps
module nps_checker
    import nps_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16,
    parameter int PGLG_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              init_done,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LEN_W-1:0]  req_len,
    input logic [PGLG_W-1:0] page_lg,
    input logic              done,
    input logic [1:0]        err,
    input logic              in_ready,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [7:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              tx_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_flags
);
    localparam int CW = LEN_W + 1;

    logic [CW-1:0] pg_c;
    logic [CW-1:0] off_c;
    assign pg_c  = CW'(1) << page_lg;
    assign off_c = CW'(cmd_addr) & (pg_c - CW'(1));

    p_prog_in_page_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PROG) |-> (cmd_len != '0) && ((off_c + CW'(cmd_len)) <= pg_c));

    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));

    p_latch_abort_r3: assert property (@(posedge clk) disable iff (rst)
        (done && err == ERR_WEL) |-> $past(rsp_valid && !rsp_flags[SR_WEL]));

    p_busy_timeout_r5: assert property (@(posedge clk) disable iff (rst)
        (done && err == ERR_NRDY) |-> $past(rsp_valid && rsp_flags[SR_WIP]));

    p_reject_uninit_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !init_done) |=> (done && err == ERR_DEV));

    p_zero_len_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && init_done && req_len == '0) |=> (done && err == ERR_NONE));

    p_data_gate_r8: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (tx_ready && !cmd_valid));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
endmodule

bind nor_prog_seq nps_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PGLG_W(PGLG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .init_done (init_done),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_len   (req_len),
    .page_lg   (page_lg),
    .done      (done),
    .err       (err),
    .in_ready  (in_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .tx_ready  (tx_ready),
    .rsp_valid (rsp_valid),
    .rsp_flags (rsp_flags)
);

// File: tb/sim_nor_prog_seq.sv
`timescale 1ns/1ps
module sim_nor_prog_seq;
    localparam int AW = 24;
    localparam int LW = 16;
    localparam int PW = 4;
    localparam int MAXP = 4;
    localparam int GAP = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          init_done = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [PW-1:0] page_lg = 4'd8;
    logic          done;
    logic [1:0]    err;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          cmd_valid;
    logic          cmd_ready = 1'b1;
    logic [7:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [LW-1:0] cmd_len;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b0;
    logic          rsp_valid = 1'b0;
    logic [1:0]    rsp_flags = '0;

    nor_prog_seq #(
        .ADDR_W(AW), .LEN_W(LW), .PGLG_W(PW), .MAX_POLLS(MAXP), .POLL_GAP(GAP)
    ) u0 (
        .clk(clk), .rst(rst), .init_done(init_done),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .page_lg(page_lg), .done(done), .err(err),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rsp_valid(rsp_valid), .rsp_flags(rsp_flags)
    );

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    // flash-side model knobs and log
    int busy_reads = 0;
    bit wel_ok = 1;
    bit stall = 0;
    int lg_n = 0;
    int lg_op[128];
    int lg_addr[128];
    int lg_len[128];
    int lg_tx[128];
    int gap_err = 0;
    int data_err = 0;
    int src_idx = 0;
    int exp_byte = 0;

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Command-port and data-source model
    initial begin
        int  cyc;
        int  pend;
        int  pend_d;
        bit  pend_poll;
        bit  poll_pending;
        int  last_rsp_cyc;
        bit  wel;
        int  busy_left;
        int  tx_left;
        int  cur_pp;
        bit  src_adv;
        cyc = 0; pend = 0; pend_d = 0; pend_poll = 0; poll_pending = 0;
        last_rsp_cyc = 0; wel = 0; busy_left = 0; tx_left = 0; cur_pp = 0; src_adv = 0;
        in_data = pat(0);
        forever begin
            @(negedge clk);
            cyc++;
            if (src_adv) begin
                src_idx++;
                in_data = pat(src_idx);
            end
            src_adv = 0;
            rsp_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rsp_valid    = 1'b1;
                    rsp_flags    = 2'(pend_d);
                    last_rsp_cyc = cyc;
                    poll_pending = pend_poll;
                end
            end
            in_valid = !stall || (cyc % 3 != 0);
            tx_ready = !stall || (cyc % 4 != 1);
            #1;
            if (!rst) begin
                if (cmd_valid && cmd_ready) begin
                    if (lg_n < 128) begin
                        lg_op[lg_n]   = int'(cmd_op);
                        lg_addr[lg_n] = int'(cmd_addr);
                        lg_len[lg_n]  = int'(cmd_len);
                        lg_tx[lg_n]   = 0;
                    end
                    case (cmd_op)
                        8'h06: begin
                            wel = wel_ok; pend = 2; pend_d = 0; pend_poll = 0;
                        end
                        8'h05: begin
                            // R4: response taken at next edge, command POLL_GAP+1 cycles later
                            if (poll_pending && (cyc - last_rsp_cyc != GAP + 2)) gap_err++;
                            pend = 2;
                            pend_d = {30'd0, wel, (busy_left > 0)};
                            pend_poll = (busy_left > 0);
                            if (busy_left > 0) busy_left--;
                        end
                        8'h02: begin
                            tx_left = int'(cmd_len);
                            busy_left = busy_reads;
                            cur_pp = lg_n;
                        end
                        default: ;
                    endcase
                    lg_n++;
                end
                if (tx_valid && tx_ready) begin
                    if (tx_data !== pat(exp_byte)) data_err++;
                    exp_byte++;
                    if (cur_pp < 128) lg_tx[cur_pp]++;
                    tx_left--;
                    if (tx_left == 0) begin
                        pend = 2; pend_d = 0; pend_poll = 1; wel = 0;
                    end
                end
                if (in_valid && in_ready) src_adv = 1;
            end
        end
    end

    task automatic run_req(input int addr, input int len, input int lg, input int busy,
                           input bit welok, input bit stl, input string tag);
        int e_op[128];
        int e_addr[128];
        int e_len[128];
        int en;
        int e_err;
        int a;
        int r;
        int pg;
        int polls;
        int t;
        bit got;
        en = 0; e_err = 0; a = addr; r = len; pg = 1 << lg;
        if (!init_done) begin
            e_err = 1;
        end else begin
            while (r > 0) begin
                int c;
                c = pg - (a % pg);
                if (r < c) c = r;
                e_op[en] = 6; e_addr[en] = 0; e_len[en] = 0; en++;
                e_op[en] = 5; e_addr[en] = 0; e_len[en] = 0; en++;
                if (!welok) begin
                    e_err = 2;
                    break;
                end
                e_op[en] = 2; e_addr[en] = a; e_len[en] = c; en++;
                polls = (busy + 1 > MAXP) ? MAXP : busy + 1;
                for (int k = 0; k < polls; k++) begin
                    e_op[en] = 5; e_addr[en] = 0; e_len[en] = 0; en++;
                end
                if (busy >= MAXP) begin
                    e_err = 3;
                    break;
                end
                a += c;
                r -= c;
            end
        end
        busy_reads = busy; wel_ok = welok; stall = stl; lg_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = AW'(addr); req_len = LW'(len); page_lg = PW'(lg);
        @(posedge clk);
        #1 req_valid = 1'b0;
        t = 0; got = 0;
        while (!got && t < 20000) begin
            @(negedge clk);
            #1;
            t++;
            if (done) got = 1;
        end
        if (!got) begin
            fails++; vectors++;
            $display("FAIL %s done: actual 0 expected 1 (addr %0d len %0d)", tag, addr, len);
        end
        if (len == 0 || e_err == 1) chk(tag, "done latency", t, 1);
        chk(tag, "err code", int'(err), e_err);
        chk(tag, "command count", lg_n, en);
        for (int i = 0; i < en && i < lg_n && i < 128; i++) begin
            chk(tag, "opcode", lg_op[i], e_op[i]);
            if (e_op[i] == 2) begin
                chk("R1", "prog addr", lg_addr[i], e_addr[i]);
                chk("R1", "prog len", lg_len[i], e_len[i]);
                chk("R8", "bytes forwarded", lg_tx[i], e_len[i]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9", "reset req_ready", int'(req_ready), 1);
        chk("R9", "reset done", int'(done), 0);
        chk("R9", "reset err", int'(err), 0);
        chk("R2", "reset cmd_valid", int'(cmd_valid), 0);
        chk("R8", "reset in_ready", int'(in_ready), 0);

        run_req(0, 8, 3, 0, 1, 0, "R6");
        init_done = 1'b1;
        run_req(5, 0, 3, 0, 1, 0, "R7");
        run_req(250, 10, 8, 1, 1, 0, "R1");
        run_req(0, 256, 8, 0, 1, 1, "R8");
        run_req(3, 9, 2, 0, 0, 0, "R3");
        run_req(6, 5, 3, MAXP - 1, 1, 1, "R5");
        run_req(6, 5, 3, MAXP, 1, 0, "R5");
        run_req(1, 7, 3, 9, 1, 0, "R5");
        run_req(2, 12, 2, 2, 1, 1, "R4");

        for (int lg = 2; lg <= 3; lg++) begin
            for (int a = 0; a < 10; a++) begin
                for (int n = 0; n <= 12; n++) begin
                    run_req(a, n, lg, (a + n) % 3, 1, bit'((a + n) % 2), "R9");
                end
            end
        end

        chk("R4", "poll spacing errors", gap_err, 0);
        chk("R8", "stream order errors", data_err, 0);
        chk("R8", "bytes consumed vs forwarded", src_idx, exp_byte);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule